// File: doc/BRIEF.md
# APM Command Port SMI Controller

This block sits behind the advanced power management command port of a platform I/O hub. When firmware or the operating system writes a byte to the command port, the block either switches ACPI mode or requests a system management interrupt (SMI) from the processor. Two reserved command values select ACPI mode on and off. They update the SCI-enable bit and never reach the processor as an SMI. Every other command value raises an SMI request, but only while an enable bit in a configuration byte is set.

The SMI request is a level held by a two-state machine. In `SMI_IDLE`, the transition RAISE moves to `SMI_PENDING` when a gated command arrives. In `SMI_PENDING`, the transition HOLD keeps the state on any cycle without a qualifying acknowledge. The transition RETIRE returns to `SMI_IDLE` on an acknowledge pulse, unless a gated command arrives in the same cycle. Requests are never queued. A companion status port next to the command port is plain read/write scratch storage.

The configuration bytes are reached through a simple byte write port with a combinational read path. Their reset values depend on a strap that reports whether SMM support is present.

Top module: `apm_smi_ctrl`

## Requirements
- R1: A write of 0xF1 to the command port (I/O address 0xB2) sets `sci_en` on the following cycle.
- R2: A write of 0xF0 to the command port clears `sci_en` on the following cycle.
- R3: Writes of 0xF0 or 0xF1 to the command port never raise `smi_req`.
- R4: A command write of any other value raises `smi_req` on the following cycle when bit 1 of configuration byte 0x5B is set. `sci_en` does not change.
- R5: A command write of any other value leaves `smi_req` low when bit 1 of configuration byte 0x5B is clear.
- R6: Once raised, `smi_req` stays high until a one-cycle `smi_ack`, and drops on the cycle after it. An `smi_ack` while idle has no effect.
- R7: A gated command that arrives while `smi_req` is already high keeps it high, and a single `smi_ack` then clears it (no second request is queued).
- R8: After reset with `smm_off_strap` low, configuration bytes 0x58 to 0x5B read 0x00, `sci_en` and `smi_req` are 0, and both ports read 0x00.
- R9: After reset with `smm_off_strap` high, configuration byte 0x5B reads 0x02 and bytes 0x58 to 0x5A read 0x00, so command writes raise SMIs without any configuration write.
- R10: The status port (I/O address 0xB3) stores the written byte and reads it back, and the write changes neither `sci_en` nor `smi_req`. The command port reads back the last command byte.
- R11: Configuration bytes 0x58 to 0x5B are writable and read back. Configuration addresses outside that range read 0x00.
- R12: A gated command in the same cycle as `smi_ack` leaves `smi_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_off_strap | input | 1 | High when SMM support is absent; sets the reset value of byte 0x5B |
| io_addr | input | 16 | I/O port address for reads and writes |
| io_wr | input | 1 | One-cycle I/O byte write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Combinational I/O read data (command or status port, else 0) |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational configuration read data |
| smi_ack | input | 1 | One-cycle acknowledge that retires a pending SMI |
| smi_req | output | 1 | Level SMI request to the processor |
| sci_en | output | 1 | ACPI mode / SCI-enable bit for the interrupt combiner |

## Verification
The hardest case to reach is a gated command that arrives in the same cycle as the acknowledge of an earlier request. Random ack pulses alone almost never line up with a command write while the request is pending. The stimulus covers it with a directed sequence: it raises a request, then drives the acknowledge and a fresh command together, and checks that the request survives that cycle and that one later acknowledge clears it. A random phase also issues a mixed command-plus-ack operation with fixed probability. This repeats the overlap many times while the enable bit is toggled.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;

    typedef enum logic [0:0] {
        SMI_IDLE    = 1'b0,
        SMI_PENDING = 1'b1
    } smi_state_e;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_ACPI_ON  = 2'd1,
        CMD_ACPI_OFF = 2'd2,
        CMD_SMI      = 2'd3
    } cmd_kind_e;

endpackage

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank #(
    parameter int               CFG_AW      = 8,
    parameter logic [CFG_AW-1:0] CFG_BASE   = 8'h58,
    parameter int               CFG_BYTES   = 4,
    parameter int               SMI_CTL_IDX = 3,
    parameter int               SMI_EN_BIT  = 1,
    parameter logic [7:0]       STRAP_RESET = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_off,
    input  logic              wr,
    input  logic [CFG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              smi_en
);

    logic [7:0] bytes_q   [CFG_BYTES];
    logic [7:0] reset_val [CFG_BYTES];

    // Per-byte reset value: only the SMI control byte follows the strap.
    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_rst
        if (g == SMI_CTL_IDX) begin : g_strap
            assign reset_val[g] = smm_off ? STRAP_RESET : 8'h00;
        end else begin : g_zero
            assign reset_val[g] = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < CFG_BYTES; i++) begin
            if (!rst_n) begin
                bytes_q[i] <= reset_val[i];
            end else if (wr && addr == CFG_AW'(int'(CFG_BASE) + i)) begin
                bytes_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < CFG_BYTES; i++) begin
            if (addr == CFG_AW'(int'(CFG_BASE) + i)) begin
                rdata = bytes_q[i];
            end
        end
    end

    assign smi_en = bytes_q[SMI_CTL_IDX][SMI_EN_BIT];

endmodule

// File: rtl/apm_port_decode.sv
module apm_port_decode
    import apm_smi_pkg::*;
#(
    parameter int               IO_AW    = 16,
    parameter logic [IO_AW-1:0] CMD_PORT = 16'h00B2,
    parameter logic [IO_AW-1:0] STS_PORT = 16'h00B3,
    parameter logic [7:0]       ACPI_ON  = 8'hF1,
    parameter logic [7:0]       ACPI_OFF = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output cmd_kind_e        kind,
    output logic             sci_en
);

    logic [7:0] cmd_q;
    logic [7:0] scratch_q;
    logic       sci_q;
    logic       cmd_hit;
    logic       sts_hit;

    assign cmd_hit = io_wr && (io_addr == CMD_PORT);
    assign sts_hit = io_wr && (io_addr == STS_PORT);

    always_comb begin
        kind = CMD_NONE;
        if (cmd_hit) begin
            if (io_wdata == ACPI_ON) begin
                kind = CMD_ACPI_ON;
            end else if (io_wdata == ACPI_OFF) begin
                kind = CMD_ACPI_OFF;
            end else begin
                kind = CMD_SMI;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= 8'h00;
            scratch_q <= 8'h00;
            sci_q     <= 1'b0;
        end else begin
            if (cmd_hit) cmd_q <= io_wdata;
            if (sts_hit) scratch_q <= io_wdata;
            unique case (kind)
                CMD_ACPI_ON:  sci_q <= 1'b1;
                CMD_ACPI_OFF: sci_q <= 1'b0;
                default:      sci_q <= sci_q;
            endcase
        end
    end

    always_comb begin
        if (io_addr == CMD_PORT) begin
            io_rdata = cmd_q;
        end else if (io_addr == STS_PORT) begin
            io_rdata = scratch_q;
        end else begin
            io_rdata = 8'h00;
        end
    end

    assign sci_en = sci_q;

endmodule

// File: rtl/apm_smi_fsm.sv
module apm_smi_fsm
    import apm_smi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_e kind,
    input  logic      smi_en,
    input  logic      smi_ack,
    output logic      smi_req
);

    smi_state_e state_q;
    smi_state_e state_d;
    logic       fire;

    assign fire = (kind == CMD_SMI) && smi_en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RAISE, HOLD, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE:    state_d = fire ? SMI_PENDING : SMI_IDLE;
            SMI_PENDING: state_d = (smi_ack && !fire) ? SMI_IDLE : SMI_PENDING;
        endcase
    end

    // Outputs
    always_comb begin
        smi_req = (state_q == SMI_PENDING);
    end

endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl
    import apm_smi_pkg::*;
#(
    parameter int                IO_AW       = 16,
    parameter logic [IO_AW-1:0]  CMD_PORT    = 16'h00B2,
    parameter logic [IO_AW-1:0]  STS_PORT    = 16'h00B3,
    parameter logic [7:0]        ACPI_ON     = 8'hF1,
    parameter logic [7:0]        ACPI_OFF    = 8'hF0,
    parameter int                CFG_AW      = 8,
    parameter logic [CFG_AW-1:0] CFG_BASE    = 8'h58,
    parameter int                CFG_BYTES   = 4,
    parameter int                SMI_CTL_IDX = 3,
    parameter int                SMI_EN_BIT  = 1,
    parameter logic [7:0]        STRAP_RESET = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_off_strap,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smi_ack,
    output logic              smi_req,
    output logic              sci_en
);

    cmd_kind_e cmd_kind;
    logic      smi_en;

    apm_cfg_bank #(
        .CFG_AW     (CFG_AW),
        .CFG_BASE   (CFG_BASE),
        .CFG_BYTES  (CFG_BYTES),
        .SMI_CTL_IDX(SMI_CTL_IDX),
        .SMI_EN_BIT (SMI_EN_BIT),
        .STRAP_RESET(STRAP_RESET)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .smm_off(smm_off_strap),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .smi_en (smi_en)
    );

    apm_port_decode #(
        .IO_AW   (IO_AW),
        .CMD_PORT(CMD_PORT),
        .STS_PORT(STS_PORT),
        .ACPI_ON (ACPI_ON),
        .ACPI_OFF(ACPI_OFF)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .kind    (cmd_kind),
        .sci_en  (sci_en)
    );

    apm_smi_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (cmd_kind),
        .smi_en (smi_en),
        .smi_ack(smi_ack),
        .smi_req(smi_req)
    );

endmodule

// File: rtl/apm_smi_chk.sv
module apm_smi_chk #(
    parameter int               IO_AW    = 16,
    parameter logic [IO_AW-1:0] CMD_PORT = 16'h00B2,
    parameter logic [7:0]       ACPI_ON  = 8'hF1,
    parameter logic [7:0]       ACPI_OFF = 8'hF0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_wr,
    input logic [IO_AW-1:0] io_addr,
    input logic [7:0]       io_wdata,
    input logic             smi_ack,
    input logic             smi_en,
    input logic             smi_req,
    input logic             sci_en
);

    logic cmd_wr;
    logic mode_cmd;
    logic gated;

    assign cmd_wr   = io_wr && (io_addr == CMD_PORT);
    assign mode_cmd = (io_wdata == ACPI_ON) || (io_wdata == ACPI_OFF);
    assign gated    = cmd_wr && !mode_cmd && smi_en;

    assert_sci_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && io_wdata == ACPI_ON) |=> sci_en);

    assert_sci_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && io_wdata == ACPI_OFF) |=> !sci_en);

    assert_mode_no_smi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && mode_cmd && !smi_req) |=> !smi_req);

    assert_smi_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gated |=> smi_req);

    assert_sci_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_wr && mode_cmd)) |=> $stable(sci_en));

    assert_smi_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !mode_cmd && !smi_en && !smi_req) |=> !smi_req);

    assert_smi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !smi_ack) |=> smi_req);

    assert_smi_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && smi_ack && !gated) |=> !smi_req);

    assert_ack_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && smi_ack && gated) |=> smi_req);

endmodule

bind apm_smi_ctrl apm_smi_chk #(
    .IO_AW   (IO_AW),
    .CMD_PORT(CMD_PORT),
    .ACPI_ON (ACPI_ON),
    .ACPI_OFF(ACPI_OFF)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .smi_ack (smi_ack),
    .smi_en  (smi_en),
    .smi_req (smi_req),
    .sci_en  (sci_en)
);

// File: tb/sim_apm_smi_ctrl.sv
`timescale 1ns/1ps
module sim_apm_smi_ctrl;

    localparam logic [15:0] CMD = 16'h00B2;
    localparam logic [15:0] STS = 16'h00B3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smm_off_strap = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        smi_ack = 1'b0;
    logic        smi_req;
    logic        sci_en;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic       m_sci, m_smi;
    logic [7:0] m_cfg [4];
    logic [7:0] m_cmd, m_scr;

    always #2 clk = ~clk;

    apm_smi_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .smm_off_strap(smm_off_strap),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .smi_ack(smi_ack), .smi_req(smi_req), .sci_en(sci_en)
    );

    function automatic logic is_mode(input logic [7:0] d);
        return (d == 8'hF0) || (d == 8'hF1);
    endfunction

    // Expected request after a cycle, from the requirements (R4, R5, R6, R7, R12)
    function automatic logic next_smi(input logic cur, input logic trig, input logic ack);
        if (trig) return 1'b1;
        if (ack)  return 1'b0;
        return cur;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input logic strap);
        m_sci = 1'b0; m_smi = 1'b0; m_cmd = 8'h00; m_scr = 8'h00;
        for (int i = 0; i < 4; i++) m_cfg[i] = 8'h00;
        if (strap) m_cfg[3] = 8'h02;
    endtask

    task automatic do_reset(input logic strap);
        smm_off_strap = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset(strap);
    endtask

    task automatic step(input bit do_io, input logic [15:0] a, input logic [7:0] d,
                        input bit do_ack);
        logic trig;
        trig = 1'b0;
        io_wr = do_io; io_addr = a; io_wdata = d; smi_ack = do_ack;
        if (do_io && a == CMD) begin
            m_cmd = d;
            if (d == 8'hF1) m_sci = 1'b1;
            else if (d == 8'hF0) m_sci = 1'b0;
            else trig = m_cfg[3][1];
        end
        if (do_io && a == STS) m_scr = d;
        m_smi = next_smi(m_smi, trig, do_ack);
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0; smi_ack = 1'b0;
    endtask

    task automatic cfg_step(input int idx, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = 8'h58 + 8'(idx); cfg_wdata = d;
        m_cfg[idx] = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] v);
        io_addr = a; #0.5; v = io_rdata;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] v);
        cfg_addr = a; #0.5; v = cfg_rdata;
    endtask

    task automatic check_outs(input string tag);
        chk({tag, " smi_req"}, {7'd0, smi_req}, {7'd0, m_smi});
        chk({tag, " sci_en"},  {7'd0, sci_en},  {7'd0, m_sci});
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset(1'b0);

        // R8: reset state with strap low
        for (int i = 0; i < 4; i++) begin
            cfg_read(8'h58 + 8'(i), v);
            chk("R8 cfg byte after reset", v, 8'h00);
        end
        check_outs("R8 reset");
        io_read(CMD, v); chk("R8 command port after reset", v, 8'h00);
        io_read(STS, v); chk("R8 status port after reset", v, 8'h00);

        // R5: gated off
        step(1, CMD, 8'h55, 0);
        chk("R5 no smi with enable clear", {7'd0, smi_req}, 8'h00);
        // R1 / R3
        step(1, CMD, 8'hF1, 0);
        chk("R1 sci set", {7'd0, sci_en}, 8'h01);
        chk("R3 no smi on F1", {7'd0, smi_req}, 8'h00);

        // R11: config write and readback, out of range
        cfg_step(3, 8'h02);
        cfg_read(8'h5B, v); chk("R11 cfg 5B readback", v, 8'h02);
        cfg_step(0, 8'hC3);
        cfg_read(8'h58, v); chk("R11 cfg 58 readback", v, 8'hC3);
        cfg_read(8'h60, v); chk("R11 out-of-range cfg read", v, 8'h00);

        // R2 / R3 with enable set
        step(1, CMD, 8'hF0, 0);
        chk("R2 sci clear", {7'd0, sci_en}, 8'h00);
        chk("R3 no smi on F0", {7'd0, smi_req}, 8'h00);
        step(1, CMD, 8'hF1, 0);
        chk("R3 no smi on F1 enabled", {7'd0, smi_req}, 8'h00);

        // R4: raise
        step(1, CMD, 8'h12, 0);
        chk("R4 smi raised", {7'd0, smi_req}, 8'h01);
        chk("R4 sci unchanged", {7'd0, sci_en}, 8'h01);

        // R6 hold, R7 no queue
        repeat (3) step(0, 16'h0000, 8'h00, 0);
        chk("R6 smi held", {7'd0, smi_req}, 8'h01);
        step(1, CMD, 8'h34, 0);
        chk("R7 pending stays", {7'd0, smi_req}, 8'h01);
        step(0, 16'h0000, 8'h00, 1);
        chk("R7 one ack clears", {7'd0, smi_req}, 8'h00);
        step(0, 16'h0000, 8'h00, 0);
        chk("R7 nothing queued", {7'd0, smi_req}, 8'h00);

        // R12: ack and gated command together
        step(1, CMD, 8'h56, 0);
        chk("R12 raise before overlap", {7'd0, smi_req}, 8'h01);
        step(1, CMD, 8'h57, 1);
        chk("R12 overlap keeps request", {7'd0, smi_req}, 8'h01);
        step(0, 16'h0000, 8'h00, 1);
        chk("R12 later ack clears", {7'd0, smi_req}, 8'h00);

        // R10: status port scratch, command readback
        step(1, STS, 8'hA5, 0);
        io_read(STS, v); chk("R10 status readback", v, 8'hA5);
        check_outs("R10 after status write");
        io_read(CMD, v); chk("R10 command readback", v, 8'h57);

        // R6: ack while idle
        step(0, 16'h0000, 8'h00, 1);
        chk("R6 idle ack ignored", {7'd0, smi_req}, 8'h00);

        // R9: strap high
        do_reset(1'b1);
        cfg_read(8'h5B, v); chk("R9 cfg 5B strap reset", v, 8'h02);
        cfg_read(8'h5A, v); chk("R9 cfg 5A strap reset", v, 8'h00);
        check_outs("R9 reset");
        step(1, CMD, 8'h40, 0);
        chk("R9 smi without config write", {7'd0, smi_req}, 8'h01);

        // Random phase against the model
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [7:0] d;
            op = int'($urandom % 8);
            case ($urandom % 3)
                0: d = 8'hF0;
                1: d = 8'hF1;
                default: d = 8'($urandom);
            endcase
            case (op)
                0, 1, 2, 3: step(1, CMD, d, 0);
                4: step(1, STS, 8'($urandom), 0);
                5: cfg_step(3, 8'($urandom));
                6: step(0, 16'h0000, 8'h00, 1);
                default: step(1, CMD, d, 1);
            endcase
            chk("R4 R6 random smi_req", {7'd0, smi_req}, {7'd0, m_smi});
            chk("R1 R2 random sci_en", {7'd0, sci_en}, {7'd0, m_sci});
            if (it % 16 == 0) begin
                io_read(STS, v); chk("R10 random status", v, m_scr);
                io_read(CMD, v); chk("R10 random command", v, m_cmd);
                cfg_read(8'h5B, v); chk("R11 random cfg", v, m_cfg[3]);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule